// File: doc/BRIEF.md
# Opcode-and-Step Microcode Sequencer

This block is the control unit of a CPU whose registers, memory port and arithmetic unit all share one data bus. It holds the current instruction in an instruction register that is written from the bus. It also keeps a step counter that advances on every clock. A combinational decode table turns the pair (opcode, step) into every control strobe of the machine: the strobes that put a value on the bus, the strobes that latch it, the activate strobes, and a strobe that ends the instruction by sending the step counter back to zero.

The instruction word has four 16-bit fields. The top field is the opcode and feeds only the decode table. Each of the three lower fields can be put on the bus, zero-extended, as an immediate value or an address. Steps 0 and 1 of every instruction are a fixed fetch sequence. The opcode selects the rest of the steps from a small example table.

Top module: `uc_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising edge, the step counter and the whole instruction register are cleared to zero. Right after reset, `step_o` is 0, `opcode_o` is 0 and `field_oe_o` is 0.
- R2: At each rising edge where the step-reset strobe (`ctl_o[15]`) is low, the step counter increases by one.
- R3: At a rising edge where `ctl_o[15]` is high, the step counter returns to 0, and the next fetch begins.
- R4: In step 0, `ctl_o` is 16'h0101: PC to bus on bit 0, memory-address load on bit 8. In step 1, `ctl_o` is 16'h0482: memory to bus on bit 1, PC increment on bit 7, instruction-register load on bit 10. Both values hold whatever the opcode is.
- R5: The instruction register captures `bus_i` at the edge that ends step 1. `opcode_o` then shows bits 63:48 of the captured word.
- R6: The field-drive strobes are bit 3 (field A = bits 15:0), bit 4 (field B = bits 31:16) and bit 5 (field C = bits 47:32). When one of them is high, `field_o` carries that field zero-extended and `field_oe_o` is 1. When none is high, `field_o` is 0 and `field_oe_o` is 0.
- R7: At most one of the bus-store strobes (`ctl_o[5:0]`: PC, memory, ALU, field A, B, C) is high in any step.
- R8: The example table gives these strobes from step 2 onward. Opcode 1 (load immediate): 16'h8808. Opcode 2 (memory to operand B): 16'h0108, then 16'h9002. Opcode 3 (ALU op): 16'h2010, then 16'h0108, then 16'h8204. Opcode 4 (jump): 16'h8060. Opcode 5 (condition set): 16'hC004. The other strobe bits are: 2 ALU store, 6 PC load, 9 memory load, 11 operand A load, 12 operand B load, 13 operator load, 14 condition load.
- R9: Opcode 0, and every opcode that is not in the table, produces 16'h8000 in step 2. That is a one-step no-operation.
- R10: Outside the load step, `bus_i` has no effect: `opcode_o` and the driven fields keep the value captured in step 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_i | input | 64 | Current value on the shared data bus |
| ctl_o | output | 16 | Control strobes for all bus components, including the step reset on bit 15 |
| opcode_o | output | 16 | Opcode field of the held instruction |
| step_o | output | 4 | Current step within the instruction |
| field_o | output | 64 | Selected instruction field, zero-extended, for the bus driver |
| field_oe_o | output | 1 | Enable for the field bus driver |

## Verification
If the step counter is wrong, `ctl_o` shows it at the next sample: a fetch pattern appears where an execute pattern belongs, or the other way round. A counter that misses its reset makes step 0 fail to return one cycle after the last strobe. If the instruction register is corrupted, or it picks up the bus outside step 1, the fault is visible in `opcode_o` and in the step-2 strobes within one cycle of the load. It stays visible in `field_o` for the later steps of the same instruction, so every scenario changes the bus right after the load.

// File: rtl/uc_seq_pkg.sv
// Shared widths, control-strobe bit positions and example opcodes.
// Assumes one 16-bit strobe vector; bit positions are visible at the ports.
package uc_seq_pkg;
    localparam int WORD_W  = 64;
    localparam int FIELD_W = 16;
    localparam int STEP_W  = 4;
    localparam int CTL_W   = 16;
    localparam int N_FLD   = 3;

    // store strobes occupy the low bits, loads and activates above
    localparam int C_PC_ST   = 0;
    localparam int C_MEM_ST  = 1;
    localparam int C_ALU_ST  = 2;
    localparam int C_FA_ST   = 3;
    localparam int C_FB_ST   = 4;
    localparam int C_FC_ST   = 5;
    localparam int C_PC_LD   = 6;
    localparam int C_PC_INC  = 7;
    localparam int C_MAR_LD  = 8;
    localparam int C_MEM_LD  = 9;
    localparam int C_IR_LD   = 10;
    localparam int C_OPA_LD  = 11;
    localparam int C_OPB_LD  = 12;
    localparam int C_OPR_LD  = 13;
    localparam int C_COND_LD = 14;
    localparam int C_STEP_RST = 15;
    localparam int N_STORE   = 6;

    typedef logic [CTL_W-1:0] ctl_t;

    localparam logic [FIELD_W-1:0] OP_NOP  = 16'd0;
    localparam logic [FIELD_W-1:0] OP_LDI  = 16'd1;
    localparam logic [FIELD_W-1:0] OP_LDM  = 16'd2;
    localparam logic [FIELD_W-1:0] OP_ALU  = 16'd3;
    localparam logic [FIELD_W-1:0] OP_JMP  = 16'd4;
    localparam logic [FIELD_W-1:0] OP_SETC = 16'd5;
endpackage

// File: rtl/uc_step_counter.sv
// Step counter: counts clocks within one instruction.
// Assumes clr comes from the decode table of the same cycle; wraps at 2**W.
module uc_step_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] step
);
    logic [W-1:0] step_q;

    // advance each clock, or go back to zero at the end of an instruction
    always_ff @(posedge clk) begin
        if (!rst_n)   step_q <= '0;
        else if (clr) step_q <= '0;
        else          step_q <= step_q + 1'b1;
    end

    assign step = step_q;

    // R3
    step_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> step_q == '0);
    // R2
    step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> step_q == W'($past(step_q) + 1'b1));
endmodule

// File: rtl/uc_instr_reg.sv
// Instruction register with an opcode tap and three drivable low fields.
// Assumes at most one bit of fld_sel is set; unselected output reads zero.
module uc_instr_reg #(
    parameter int WORD_W  = 64,
    parameter int FIELD_W = 16,
    parameter int N_FLD   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [WORD_W-1:0]  bus_in,
    input  logic [N_FLD-1:0]   fld_sel,
    output logic [FIELD_W-1:0] opcode,
    output logic [WORD_W-1:0]  fld_out,
    output logic               fld_oe
);
    localparam int OPC_LSB = N_FLD * FIELD_W;

    logic [WORD_W-1:0]  ir_q;
    logic [WORD_W-1:0]  fld_part [N_FLD];

    // capture the bus only on the load strobe
    always_ff @(posedge clk) begin
        if (!rst_n)    ir_q <= '0;
        else if (load) ir_q <= bus_in;
    end

    assign opcode = ir_q[OPC_LSB +: FIELD_W];

    // one masked, zero-extended copy per drivable field
    for (genvar g = 0; g < N_FLD; g++) begin : g_fld
        assign fld_part[g] = fld_sel[g]
            ? {{(WORD_W-FIELD_W){1'b0}}, ir_q[g*FIELD_W +: FIELD_W]}
            : '0;
    end

    // merge the masked fields into the driver value
    always_comb begin
        fld_out = '0;
        for (int i = 0; i < N_FLD; i++) fld_out = fld_out | fld_part[i];
    end

    assign fld_oe = |fld_sel;

    // R5
    ir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ir_q == $past(bus_in));
    // R10
    ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(ir_q));
endmodule

// File: rtl/uc_decode_table.sv
// Decode table: maps (opcode, step) to every control strobe.
// Assumes steps 0 and 1 are fetch for all opcodes; unknown opcodes end at step 2.
module uc_decode_table
    import uc_seq_pkg::*;
#(
    parameter int OPC_W  = 16,
    parameter int STEP_W = 4
) (
    input  logic [OPC_W-1:0]  opcode,
    input  logic [STEP_W-1:0] step,
    output ctl_t              ctl
);
    // table lookup: fetch first, then per-opcode execute steps
    always_comb begin
        ctl = '0;
        if (step == STEP_W'(0)) begin
            ctl[C_PC_ST]  = 1'b1;
            ctl[C_MAR_LD] = 1'b1;
        end else if (step == STEP_W'(1)) begin
            ctl[C_MEM_ST] = 1'b1;
            ctl[C_IR_LD]  = 1'b1;
            ctl[C_PC_INC] = 1'b1;
        end else begin
            case (opcode)
                OP_LDI: begin
                    ctl[C_FA_ST]    = 1'b1;
                    ctl[C_OPA_LD]   = 1'b1;
                    ctl[C_STEP_RST] = 1'b1;
                end
                OP_LDM: begin
                    if (step == STEP_W'(2)) begin
                        ctl[C_FA_ST]  = 1'b1;
                        ctl[C_MAR_LD] = 1'b1;
                    end else begin
                        ctl[C_MEM_ST]   = 1'b1;
                        ctl[C_OPB_LD]   = 1'b1;
                        ctl[C_STEP_RST] = 1'b1;
                    end
                end
                OP_ALU: begin
                    if (step == STEP_W'(2)) begin
                        ctl[C_FB_ST]  = 1'b1;
                        ctl[C_OPR_LD] = 1'b1;
                    end else if (step == STEP_W'(3)) begin
                        ctl[C_FA_ST]  = 1'b1;
                        ctl[C_MAR_LD] = 1'b1;
                    end else begin
                        ctl[C_ALU_ST]   = 1'b1;
                        ctl[C_MEM_LD]   = 1'b1;
                        ctl[C_STEP_RST] = 1'b1;
                    end
                end
                OP_JMP: begin
                    ctl[C_FC_ST]    = 1'b1;
                    ctl[C_PC_LD]    = 1'b1;
                    ctl[C_STEP_RST] = 1'b1;
                end
                OP_SETC: begin
                    ctl[C_ALU_ST]   = 1'b1;
                    ctl[C_COND_LD]  = 1'b1;
                    ctl[C_STEP_RST] = 1'b1;
                end
                default: ctl[C_STEP_RST] = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/uc_sequencer.sv
// Top of the control unit: instruction register, step counter, decode table.
// Assumes the bus value is valid in step 1; outputs are combinational from state.
module uc_sequencer
    import uc_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WORD_W-1:0]  bus_i,
    output logic [CTL_W-1:0]   ctl_o,
    output logic [FIELD_W-1:0] opcode_o,
    output logic [STEP_W-1:0]  step_o,
    output logic [WORD_W-1:0]  field_o,
    output logic               field_oe_o
);
    ctl_t               ctl;
    logic [STEP_W-1:0]  step;
    logic [FIELD_W-1:0] opcode;

    uc_step_counter #(.W(STEP_W)) u_step (
        .clk(clk), .rst_n(rst_n), .clr(ctl[C_STEP_RST]), .step(step)
    );

    uc_instr_reg #(.WORD_W(WORD_W), .FIELD_W(FIELD_W), .N_FLD(N_FLD)) u_ir (
        .clk(clk), .rst_n(rst_n), .load(ctl[C_IR_LD]), .bus_in(bus_i),
        .fld_sel(ctl[C_FC_ST:C_FA_ST]), .opcode(opcode),
        .fld_out(field_o), .fld_oe(field_oe_o)
    );

    uc_decode_table #(.OPC_W(FIELD_W), .STEP_W(STEP_W)) u_dec (
        .opcode(opcode), .step(step), .ctl(ctl)
    );

    assign ctl_o    = ctl;
    assign opcode_o = opcode;
    assign step_o   = step;

    // R7
    one_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctl[N_STORE-1:0]));
    // R4
    fetch_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step == '0) |=> (step == STEP_W'(1)) && ctl[C_IR_LD]);
    // R3
    end_to_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl[C_STEP_RST] |=> ctl[C_PC_ST] && ctl[C_MAR_LD]);
    // R6
    field_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !field_oe_o |-> field_o == '0);
endmodule

// File: tb/sim_uc_sequencer.sv
// Directed bench: one task per scenario, each checks its own results.
module sim_uc_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] bus_i = '0;
    logic [15:0] ctl_o;
    logic [15:0] opcode_o;
    logic [3:0]  step_o;
    logic [63:0] field_o;
    logic        field_oe_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    uc_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .bus_i(bus_i), .ctl_o(ctl_o),
        .opcode_o(opcode_o), .step_o(step_o), .field_o(field_o),
        .field_oe_o(field_oe_o)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        bus_i = 64'hFFFF_AAAA_5555_1234;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 step", 64'(step_o), 64'd0);
        chk("R1 opcode", 64'(opcode_o), 64'd0);
        chk("R1 field_oe", 64'(field_oe_o), 64'd0);
        chk("R1 ctl", 64'(ctl_o), 64'h0101);
    endtask

    // fetch word; return at negedge of step 2 with bus scrambled
    task automatic fetch(input logic [63:0] w);
        chk("R4 step0 ctl", 64'(ctl_o), 64'h0101);
        bus_i = w;
        @(negedge clk);
        chk("R2 step1", 64'(step_o), 64'd1);
        chk("R4 step1 ctl", 64'(ctl_o), 64'h0482);
        @(negedge clk);
        bus_i = ~w;
        chk("R2 step2", 64'(step_o), 64'd2);
        chk("R5 opcode", 64'(opcode_o), 64'(w[63:48]));
    endtask

    task automatic expect_back_to_fetch();
        @(negedge clk);
        chk("R3 step0", 64'(step_o), 64'd0);
        chk("R3 fetch", 64'(ctl_o), 64'h0101);
    endtask

    task automatic t_nop(input logic [63:0] w);
        fetch(w);
        chk("R9 ctl", 64'(ctl_o), 64'h8000);
        chk("R6 no drive", 64'(field_oe_o), 64'd0);
        chk("R6 zero", field_o, 64'd0);
        expect_back_to_fetch();
    endtask

    task automatic t_ldi();
        logic [63:0] w = 64'h0001_1111_2222_BEEF;
        fetch(w);
        chk("R8 ldi ctl", 64'(ctl_o), 64'h8808);
        chk("R6 field A", field_o, 64'h0000_0000_0000_BEEF);
        chk("R6 oe", 64'(field_oe_o), 64'd1);
        expect_back_to_fetch();
    endtask

    task automatic t_ldm();
        logic [63:0] w = 64'h0002_3333_4444_0042;
        fetch(w);
        chk("R8 ldm s2", 64'(ctl_o), 64'h0108);
        chk("R6 field A", field_o, 64'h42);
        @(negedge clk);
        chk("R2 step3", 64'(step_o), 64'd3);
        chk("R8 ldm s3", 64'(ctl_o), 64'h9002);
        expect_back_to_fetch();
    endtask

    task automatic t_alu();
        logic [63:0] w = 64'h0003_7777_ABCD_0100;
        fetch(w);
        chk("R8 alu s2", 64'(ctl_o), 64'h2010);
        chk("R6 field B", field_o, 64'hABCD);
        @(negedge clk);
        bus_i = 64'h0;
        chk("R8 alu s3", 64'(ctl_o), 64'h0108);
        chk("R10 field A held", field_o, 64'h0100);
        @(negedge clk);
        chk("R2 step4", 64'(step_o), 64'd4);
        chk("R8 alu s4", 64'(ctl_o), 64'h8204);
        chk("R10 opcode held", 64'(opcode_o), 64'd3);
        chk("R7 one store", 64'($countones(ctl_o[5:0]) <= 1), 64'd1);
        expect_back_to_fetch();
    endtask

    task automatic t_jmp();
        logic [63:0] w = 64'h0004_C0DE_2222_3333;
        fetch(w);
        chk("R8 jmp ctl", 64'(ctl_o), 64'h8060);
        chk("R6 field C", field_o, 64'hC0DE);
        expect_back_to_fetch();
    endtask

    task automatic t_setc();
        logic [63:0] w = 64'h0005_0000_0000_0000;
        fetch(w);
        chk("R8 setc ctl", 64'(ctl_o), 64'hC004);
        chk("R7 one store", 64'($countones(ctl_o[5:0]) <= 1), 64'd1);
        expect_back_to_fetch();
    endtask

    task automatic t_reset_mid();
        logic [63:0] w = 64'h0003_0000_0000_0000;
        fetch(w);
        do_reset();
    endtask

    initial begin
        do_reset();
        t_nop(64'h0000_1234_5678_9ABC);
        t_ldi();
        t_ldm();
        t_alu();
        t_jmp();
        t_setc();
        t_nop(64'h7777_FFFF_FFFF_FFFF);
        t_reset_mid();
        t_ldi();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule